// File: doc/BRIEF.md
# Chained TDM Converter-Output Serializer

This block places four parallel converter words on a single time-division-multiplexed serial line and forwards the line of an upstream device of the same kind, so that several devices can share one receiver pin. The block runs on the serial bit clock. A frame-sync pulse on a rising edge starts a frame. At that edge the four local words are copied into a holding register. During the frame the block drives them MSB first into the first four 32-bit slots, in the order L1, R1, L2, R2.

The serial line arriving from the upstream device is sampled on rising edges and delayed through a shift path of four slots (128 bit periods). It then appears in slots 4 to 7, directly after the local channels. A two-device chain at 512 bit clocks per sample period gives a frame of 16 slots. The slots after the chained ones carry zero. Output bits change on falling edges, so a receiver can sample them on rising edges.

Top module: `tdm_chain_ser`

## Requirements
- R1: After reset, and until the first frame-sync is seen, `sdo` is held low whatever `chain_in` carries.
- R2: A high `fsync` at a rising edge of `bclk` sets the frame position to bit 0. After the next falling edge, `sdo` carries frame bit 0. The position advances by one per bit clock and a pulse in mid-frame restarts it at bit 0.
- R3: Frame bit `p`, with slot `s = p/32` and offset `b = p%32`, carries bit `23-b` of held word `s` when `s` is below 4 and `b` is below 24. Word index 0..3 of `ch_words` is L1, R1, L2, R2.
- R4: In the local slots, offsets 24 to 31 carry zero.
- R5: In slots 4 to 7, frame bit `p` equals the `chain_in` value sampled 127 rising edges before the edge that set position `p`. This is a delay of exactly 128 bit periods.
- R6: Slots 8 to 15 (frame bits 256..511) carry zero.
- R7: `ch_words` is copied only on a frame-sync edge. A change in mid-frame does not alter the current frame.
- R8: While `chain_in` is held low, slots 4 to 7 carry zero.
- R9: If no frame-sync comes, the position wraps from bit 511 to bit 0 and the held words are sent again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsync | input | 1 | Frame-sync pulse marking slot 0, sampled on rising edges |
| ch_words | input | 4x24 | Local channel words; index 0..3 is L1, R1, L2, R2 |
| chain_in | input | 1 | Serial TDM line from the upstream device |
| sdo | output | 1 | Serial TDM output, updated on falling edges |

## Verification
Random words with a random upstream stream separate a correct slot and bit order from swapped channels, reversed bit order, and a chain delay that is off by one bit. Words of all ones and MSB-only words expose padding that leaks into the eight trailing bits and a frame start that is off by one bit. Mid-frame word changes, a held-low upstream line, a frame with no sync and a mid-frame sync then show apart a hold register that tracks its input, chained slots with stale contents, and a counter that stops or fails to restart.

// File: rtl/tdm_chain_pkg.sv
package tdm_chain_pkg;
   typedef enum logic [1:0] {
      SLOT_LOCAL = 2'd0,
      SLOT_CHAIN = 2'd1,
      SLOT_IDLE  = 2'd2
   } slot_kind_e;

   // Slot ownership: local words first, forwarded upstream slots next, zero after.
   function automatic slot_kind_e classify_slot(input int slot, input int n_local,
                                                input int n_chain);
      if (slot < n_local)                return SLOT_LOCAL;
      else if (slot < n_local + n_chain) return SLOT_CHAIN;
      else                               return SLOT_IDLE;
   endfunction
endpackage

// File: rtl/tdm_frame_counter.sv
module tdm_frame_counter #(
   parameter int FRAME_BITS = 512,
   localparam int PW = $clog2(FRAME_BITS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sync,
   output logic [PW-1:0] pos,
   output logic          framed
);
   localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos    <= '0;
         framed <= 1'b0;
      end else if (sync) begin
         pos    <= '0;
         framed <= 1'b1;
      end else if (framed) begin
         pos <= (pos == LAST) ? '0 : pos + 1'b1;
      end
   end
endmodule

// File: rtl/tdm_sample_hold.sv
module tdm_sample_hold #(
   parameter int CH = 4,
   parameter int W  = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [CH-1:0][W-1:0] din,
   output logic [CH-1:0][W-1:0] dout
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    dout <= '0;
      else if (load) dout <= din;
   end
endmodule

// File: rtl/tdm_chain_delay.sv
module tdm_chain_delay #(
   parameter int DEPTH = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic tap
);
   generate
      if (DEPTH == 0) begin : g_thru
         assign tap = din;
      end else if (DEPTH == 1) begin : g_one
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= din;
         end
         assign tap = q;
      end else begin : g_shift
         logic [DEPTH-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '0;
            else        sr <= {sr[DEPTH-2:0], din};
         end
         assign tap = sr[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/tdm_chain_ser.sv
module tdm_chain_ser
   import tdm_chain_pkg::*;
#(
   parameter int SAMPLE_W    = 24,
   parameter int SLOT_W      = 32,
   parameter int LOCAL_CH    = 4,
   parameter int CHAIN_CH    = 4,
   parameter int FRAME_SLOTS = 16
) (
   input  logic                             bclk,
   input  logic                             rst_n,
   input  logic                             fsync,
   input  logic [LOCAL_CH-1:0][SAMPLE_W-1:0] ch_words,
   input  logic                             chain_in,
   output logic                             sdo
);
   localparam int FRAME_BITS = SLOT_W * FRAME_SLOTS;
   localparam int PW         = $clog2(FRAME_BITS);
   localparam int SLOT_BITS  = $clog2(SLOT_W);
   localparam int CH_IW      = (LOCAL_CH > 1) ? $clog2(LOCAL_CH) : 1;
   localparam int SW_IW      = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1;
   localparam int DELAY_BITS = LOCAL_CH * SLOT_W;

   generate
      if (SAMPLE_W < 1 || SAMPLE_W > SLOT_W) begin : g_bad_width
         $error("SAMPLE_W must lie in 1..SLOT_W");
      end
      if ((1 << SLOT_BITS) != SLOT_W) begin : g_bad_slot
         $error("SLOT_W must be a power of two");
      end
      if (LOCAL_CH < 1 || LOCAL_CH + CHAIN_CH > FRAME_SLOTS) begin : g_bad_slots
         $error("local plus chained slots must fit in the frame");
      end
   endgenerate

   logic [PW-1:0]                     frame_pos;
   logic                              in_frame;
   logic [LOCAL_CH-1:0][SAMPLE_W-1:0] held_words;
   logic                              chain_tap;

   tdm_frame_counter #(.FRAME_BITS(FRAME_BITS)) u_cnt (
      .clk(bclk), .rst_n(rst_n), .sync(fsync), .pos(frame_pos), .framed(in_frame)
   );

   tdm_sample_hold #(.CH(LOCAL_CH), .W(SAMPLE_W)) u_hold (
      .clk(bclk), .rst_n(rst_n), .load(fsync), .din(ch_words), .dout(held_words)
   );

   tdm_chain_delay #(.DEPTH(DELAY_BITS)) u_dly (
      .clk(bclk), .rst_n(rst_n), .din(chain_in), .tap(chain_tap)
   );

   logic [PW-SLOT_BITS-1:0] slot_idx;
   logic [SLOT_BITS-1:0]    slot_off;
   logic [CH_IW-1:0]        ch_sel;
   logic [SW_IW-1:0]        bit_sel;
   logic                    next_bit;

   assign slot_idx = frame_pos[PW-1:SLOT_BITS];
   assign slot_off = frame_pos[SLOT_BITS-1:0];
   assign ch_sel   = CH_IW'(slot_idx);
   assign bit_sel  = SW_IW'(SAMPLE_W - 1 - int'(slot_off));

   always_comb begin
      next_bit = 1'b0;
      if (in_frame) begin
         unique case (classify_slot(int'(slot_idx), LOCAL_CH, CHAIN_CH))
            SLOT_LOCAL: if (int'(slot_off) < SAMPLE_W) next_bit = held_words[ch_sel][bit_sel];
            SLOT_CHAIN: next_bit = chain_tap;
            default:    next_bit = 1'b0;
         endcase
      end
   end

   // Launch on the falling edge so the receiver samples on the rising edge.
   always_ff @(negedge bclk or negedge rst_n) begin
      if (!rst_n) sdo <= 1'b0;
      else        sdo <= next_bit;
   end
endmodule

// File: rtl/tdm_chain_ser_chk.sv
module tdm_chain_ser_chk #(
   parameter int SAMPLE_W    = 24,
   parameter int SLOT_W      = 32,
   parameter int LOCAL_CH    = 4,
   parameter int CHAIN_CH    = 4,
   parameter int FRAME_SLOTS = 16,
   localparam int FRAME_BITS = SLOT_W * FRAME_SLOTS,
   localparam int PW         = $clog2(FRAME_BITS)
) (
   input logic                             bclk,
   input logic                             rst_n,
   input logic                             fsync,
   input logic                             sdo,
   input logic [PW-1:0]                    pos,
   input logic                             framed,
   input logic [LOCAL_CH-1:0][SAMPLE_W-1:0] hold
);
   localparam int LOCAL_END = LOCAL_CH * SLOT_W;
   localparam int USED_END  = (LOCAL_CH + CHAIN_CH) * SLOT_W;

   a_r1_idle_quiet: assert property (@(posedge bclk) disable iff (!rst_n)
      !framed |-> !sdo);

   a_r2_sync_restart: assert property (@(posedge bclk) disable iff (!rst_n)
      fsync |=> (pos == '0) && framed);

   a_r2_advance: assert property (@(posedge bclk) disable iff (!rst_n)
      (framed && !fsync) |=>
         (int'(pos) == ((int'($past(pos)) == FRAME_BITS - 1) ? 0 : int'($past(pos)) + 1)));

   a_r4_pad_zero: assert property (@(posedge bclk) disable iff (!rst_n)
      (framed && int'(pos) < LOCAL_END && (int'(pos) % SLOT_W) >= SAMPLE_W) |-> !sdo);

   a_r6_unused_zero: assert property (@(posedge bclk) disable iff (!rst_n)
      (framed && int'(pos) >= USED_END) |-> !sdo);

   a_r7_hold_frozen: assert property (@(posedge bclk) disable iff (!rst_n)
      !fsync |=> $stable(hold));
endmodule

bind tdm_chain_ser tdm_chain_ser_chk #(
   .SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .LOCAL_CH(LOCAL_CH),
   .CHAIN_CH(CHAIN_CH), .FRAME_SLOTS(FRAME_SLOTS)
) u_chk (
   .bclk(bclk), .rst_n(rst_n), .fsync(fsync), .sdo(sdo),
   .pos(frame_pos), .framed(in_frame), .hold(held_words)
);

// File: tb/tdm_chain_ser_test.sv
`timescale 1ns/1ps
module tdm_chain_ser_test;
   localparam int W     = 24;
   localparam int NCH   = 4;
   localparam int FBITS = 512;

   logic                   bclk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   fsync = 1'b0;
   logic [NCH-1:0][W-1:0]  ch_words = '0;
   logic                   chain_in = 1'b0;
   logic                   sdo;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 bclk = ~bclk;

   tdm_chain_ser uut (
      .bclk(bclk), .rst_n(rst_n), .fsync(fsync), .ch_words(ch_words),
      .chain_in(chain_in), .sdo(sdo)
   );

   // Reference model state
   int                    m_pos = 0;
   bit                    m_framed = 1'b0;
   logic [NCH-1:0][W-1:0] m_hold = '0;
   bit                    hist[256];
   int                    edges = 0;
   bit                    exp_sdo = 1'b0;
   string                 exp_tag = "R1";
   string                 tag_local = "R3";
   string                 tag_chain = "R5";

   task automatic check(input string tag, input bit act, input bit exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0b expected %0b (t=%0t)", tag, what, act, exp, $time);
      end
   endtask

   function automatic bit exp_bit(input int p, input bit tap, output string tag);
      int s = p / 32;
      int b = p % 32;
      if (s < NCH) begin
         if (b < W) begin
            tag = (p == 0) ? "R2" : tag_local;
            return m_hold[s][W-1-b];
         end
         tag = "R4";
         return 1'b0;
      end else if (s < 2 * NCH) begin
         tag = tag_chain;
         return tap;
      end
      tag = "R6";
      return 1'b0;
   endfunction

   // One bit period: check the bit launched at this falling edge, then drive.
   task automatic step(input bit fs, input bit d);
      bit tap;
      @(negedge bclk);
      #1;
      check(exp_tag, sdo, exp_sdo, $sformatf("frame bit %0d", m_pos));
      fsync    = fs;
      chain_in = d;
      hist[edges % 256] = d;
      tap = (edges >= 127) ? hist[(edges - 127) % 256] : 1'b0;
      edges++;
      if (fs) begin
         m_pos = 0; m_framed = 1'b1; m_hold = ch_words;
      end else if (m_framed) begin
         m_pos = (m_pos + 1) % FBITS;
      end
      if (!m_framed) begin
         exp_sdo = 1'b0; exp_tag = "R1";
      end else begin
         exp_sdo = exp_bit(m_pos, tap, exp_tag);
      end
   endtask

   function automatic logic [W-1:0] rnd_word();
      return W'($urandom);
   endfunction

   task automatic rnd_words();
      for (int i = 0; i < NCH; i++) ch_words[i] = rnd_word();
   endtask

   task automatic run_frame(input bit with_sync, input int mode_sdi);
      for (int k = 0; k < FBITS; k++) begin
         bit d = (mode_sdi == 0) ? 1'b0 : 1'($urandom);
         step(with_sync && k == 0, d);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      // R1: reset state
      for (int i = 0; i < 3; i++) begin
         @(negedge bclk); #1;
         check("R1", sdo, 1'b0, "output during reset");
      end
      @(posedge bclk); #1;
      rst_n = 1'b1;

      // R1: idle before first sync, upstream line toggling
      for (int i = 0; i < 40; i++) step(1'b0, 1'($urandom));

      // R3/R5: random words and random upstream data
      rnd_words();
      run_frame(1'b1, 1);

      // R2/R4: directed words, MSB-only and all-ones patterns
      ch_words[0] = 24'h800000;
      ch_words[1] = 24'hFFFFFF;
      ch_words[2] = 24'h000001;
      ch_words[3] = 24'hA5A5A5;
      run_frame(1'b1, 1);

      // R7: words change in mid-frame; the frame keeps the captured ones
      rnd_words();
      tag_local = "R7";
      for (int k = 0; k < FBITS; k++) begin
         if (k == 20 || k == 70 || k == 100) rnd_words();
         step(k == 0, 1'($urandom));
      end
      tag_local = "R3";

      // R8: upstream held low; chained slots carry zero
      tag_chain = "R8";
      run_frame(1'b1, 0);
      run_frame(1'b1, 0);
      tag_chain = "R5";

      // R9: no sync, position wraps and repeats the held words
      tag_local = "R9";
      rnd_words();
      run_frame(1'b0, 1);
      tag_local = "R3";

      // R2: sync in mid-frame restarts at bit 0
      rnd_words();
      for (int k = 0; k < 100; k++) step(k == 0, 1'($urandom));
      rnd_words();
      run_frame(1'b1, 1);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      finish_run();
   end
endmodule